// File: doc/BRIEF.md
# Sub-Second Masked Alarm Comparator

This block watches the sub-second counter of a real-time clock and raises an alarm when that count agrees with a programmed value. It contains the sub-second counter itself. The counter is 16 bits wide: 15 count bits and an overflow bit above them. It counts down from a programmable prescale value to zero and then reloads. The cycle in which it reloads is the seconds strobe. A compare register holds a 4-bit mask count and a 15-bit target value. The mask count says how many low-order counter bits take part in the comparison. A mask count of zero ignores the counter bits and triggers on the seconds strobe instead.

Calendar matching happens outside the block. The result arrives on one input that qualifies every alarm. Each new match produces a one-cycle pulse and sets a sticky flag, which software clears by writing a one. The pulse also reaches an interrupt output while the interrupt enable is set. Writes to the compare register are guarded twice: a write needs the unlock input, and it is refused while the interrupt is enabled unless the block is in initialization mode. A shift input adds a value to the count bits, and the carry of that addition lands in the overflow bit.

Register map, selected by a 2-bit address:
- Address 0 is the compare register. The mask count is in bits 27:24 and the target value in bits 14:0.
- Address 1 is control. The prescale value is in bits 14:0 and the interrupt enable in bit 16.
- Address 2 is status. The flag is in bit 0, and writing 1 to that bit clears the flag.
- Address 3 is the 16-bit counter, readable only.

Top module: `ss_alarm`

## Requirements
- R1: After reset the compare register, the flag, the interrupt enable and the counter read zero, and the prescale value reads 255 (control reads 0x000000FF).
- R2: While no shift is applied, the counter decrements by one each cycle. In the cycle after it reads zero it holds the prescale value. The sec_tick output is high exactly while the counter reads zero.
- R3: With mask count 0, a match occurs in every cycle where the counter reads zero (the seconds strobe).
- R4: With mask count n from 1 to 14, a match requires only counter bits [n-1:0] to equal target bits [n-1:0]. Target bits [14:n] have no effect.
- R5: With mask count 15, all 15 count bits must equal the target.
- R6: A shift adds shift_val to counter bits 14:0, and the carry goes into bit 15. Bit 15 never takes part in any comparison.
- R7: No match occurs while other_match is low.
- R8: A compare write is ignored while the interrupt enable is set, unless init_mode is high.
- R9: Writes to the compare and control registers take effect only while wr_unlock is high.
- R10: Compare bits 31:28 and 23:15 read zero whatever is written. Control bits 31:17 and 15 also read zero.
- R11: Each match event gives an alarm_pulse exactly one cycle long, in the cycle after the first matching cycle. A match that persists gives no second pulse. The pulse sets alarm_flag. A write of 1 to bit 0 of status clears the flag, but a pulse in the same cycle wins.
- R12: alarm_irq equals alarm_pulse while the interrupt enable is set, and stays low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write register select |
| wr_data | input | 32 | Write data |
| wr_unlock | input | 1 | Write protection released |
| init_mode | input | 1 | Initialization mode |
| rd_addr | input | 2 | Read register select |
| rd_data | output | 32 | Read data (combinational) |
| other_match | input | 1 | Calendar fields agree |
| shift_en | input | 1 | Apply a shift to the counter |
| shift_val | input | 15 | Amount added on a shift |
| sec_tick | output | 1 | Seconds strobe (counter reload cycle) |
| alarm_pulse | output | 1 | One-cycle alarm event |
| alarm_flag | output | 1 | Sticky alarm flag |
| alarm_irq | output | 1 | Alarm pulse gated by interrupt enable |

## Verification
Setting the alarm flag and clearing it by software can fall in the same cycle. The bench provokes this in a directed way: it waits until the counter reads the target value and presents the clear write in that very cycle. One cycle later it expects both the pulse and the flag to be high. A separate clear afterwards must then bring the flag to zero. A cycle-by-cycle model runs alongside, built only from counter values read at the ports, and predicts the pulse, the flag and the interrupt in every other scenario.

// File: rtl/ssa_pkg.sv
package ssa_pkg;
  localparam int SS_W     = 15;
  localparam int CNT_W    = SS_W + 1;
  localparam int MASK_W   = 4;
  localparam int DATA_W   = 32;
  localparam int ADDR_W   = 2;
  localparam int MASK_LSB = 24;
  localparam int IRQ_BIT  = 16;

  typedef enum logic [ADDR_W-1:0] {
    REG_CMP  = 2'd0,
    REG_CTRL = 2'd1,
    REG_STAT = 2'd2,
    REG_CNT  = 2'd3
  } ssa_addr_e;

  typedef struct packed {
    logic [MASK_W-1:0] mask;
    logic [SS_W-1:0]   ss;
  } ssa_cmp_t;

  // Next counter value: shift adds into the low bits with carry into the top bit.
  function automatic logic [CNT_W-1:0] next_count(
    input logic [CNT_W-1:0] cnt,
    input logic [SS_W-1:0]  presc,
    input logic             shift,
    input logic [SS_W-1:0]  amount
  );
    if (shift)
      return {1'b0, cnt[SS_W-1:0]} + {1'b0, amount};
    else if (cnt == '0)
      return {1'b0, presc};
    else
      return cnt - CNT_W'(1);
  endfunction

  // Register image of the compare register; reserved bits zero.
  function automatic logic [DATA_W-1:0] pack_cmp(input ssa_cmp_t c);
    logic [DATA_W-1:0] r;
    r = '0;
    r[MASK_LSB +: MASK_W] = c.mask;
    r[SS_W-1:0]           = c.ss;
    return r;
  endfunction

  function automatic logic [DATA_W-1:0] pack_ctrl(input logic [SS_W-1:0] presc,
                                                  input logic irq_en);
    logic [DATA_W-1:0] r;
    r = '0;
    r[SS_W-1:0] = presc;
    r[IRQ_BIT]  = irq_en;
    return r;
  endfunction
endpackage

// File: rtl/ssa_prescaler.sv
module ssa_prescaler
  import ssa_pkg::*;
#(
  parameter logic [SS_W-1:0] PRESC_RST = 15'd255
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             presc_we,
  input  logic [SS_W-1:0]  presc_wdata,
  input  logic             shift_en,
  input  logic [SS_W-1:0]  shift_val,
  output logic [CNT_W-1:0] cnt,
  output logic [SS_W-1:0]  presc,
  output logic             sec_tick
);
  logic [CNT_W-1:0] cnt_nxt;

  assign cnt_nxt  = next_count(cnt, presc, shift_en, shift_val);
  assign sec_tick = (cnt == '0) && !shift_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= '0;
      presc <= PRESC_RST;
    end else begin
      cnt <= cnt_nxt;
      if (presc_we) presc <= presc_wdata;
    end
  end

  // R2: reload from the prescale value after the zero cycle
  assert_reload_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0 && !shift_en) |=> (cnt == {1'b0, $past(presc)}));

  // R2: plain decrement otherwise
  assert_decrement_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != '0 && !shift_en) |=> (cnt == $past(cnt) - CNT_W'(1)));

  // R6: a shift keeps the low bits equal to the sum
  assert_shift_sum_R6: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> (cnt[SS_W-1:0] == $past(cnt[SS_W-1:0]) + $past(shift_val)));
endmodule

// File: rtl/ssa_cmp_reg.sv
module ssa_cmp_reg
  import ssa_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_sel,
  input  logic [MASK_W-1:0] mask_wdata,
  input  logic [SS_W-1:0]   ss_wdata,
  input  logic              wr_unlock,
  input  logic              init_mode,
  input  logic              irq_en,
  output ssa_cmp_t          cmp,
  output logic              cmp_accept
);
  assign cmp_accept = wr_sel && wr_unlock && (!irq_en || init_mode);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp <= '0;
    end else if (cmp_accept) begin
      cmp.mask <= mask_wdata;
      cmp.ss   <= ss_wdata;
    end
  end

  // R8: locked while the interrupt is enabled outside initialization
  assert_locked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en && !init_mode) |=> $stable(cmp));

  // R9: nothing changes without the unlock input
  assert_protect_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_unlock |=> $stable(cmp));
endmodule

// File: rtl/ssa_match.sv
module ssa_match
  import ssa_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [SS_W-1:0] count_low,
  input  ssa_cmp_t        cmp,
  input  logic            sec_tick,
  input  logic            other_match,
  input  logic            irq_en,
  input  logic            flag_clr,
  output logic            hit,
  output logic            alarm_pulse,
  output logic            alarm_flag,
  output logic            alarm_irq
);
  logic [SS_W-1:0] bit_ok;
  logic            hit_d;
  logic            hit_rise;

  // Bit i is compared only when its index lies below the mask count.
  for (genvar i = 0; i < SS_W; i++) begin : g_bit
    localparam logic [MASK_W:0] IDX = (MASK_W+1)'(i);
    assign bit_ok[i] = (IDX >= {1'b0, cmp.mask}) || (count_low[i] == cmp.ss[i]);
  end

  assign hit      = other_match && ((cmp.mask == '0) ? sec_tick : (&bit_ok));
  assign hit_rise = hit && !hit_d;
  assign alarm_irq = alarm_pulse && irq_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hit_d       <= 1'b0;
      alarm_pulse <= 1'b0;
      alarm_flag  <= 1'b0;
    end else begin
      hit_d       <= hit;
      alarm_pulse <= hit_rise;
      if (hit_rise)      alarm_flag <= 1'b1;
      else if (flag_clr) alarm_flag <= 1'b0;
    end
  end

  // R11: never two pulses back to back
  assert_single_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_pulse |=> !alarm_pulse);

  // R11: a pulse always leaves the flag set, even against a clear
  assert_flag_set_R11: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_pulse |-> alarm_flag);

  // R3: with a zero mask count, a match needs the counter at zero
  assert_mask0_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && cmp.mask == '0) |-> (count_low == '0));

  // R7: the calendar qualifier gates every match
  assert_qualified_R7: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> other_match);

  // R12: interrupt only with a pulse and the enable
  assert_irq_gate_R12: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_irq |-> (alarm_pulse && irq_en));
endmodule

// File: rtl/ss_alarm.sv
module ss_alarm
  import ssa_pkg::*;
#(
  parameter logic [SS_W-1:0] PRESC_RST = 15'd255
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_unlock,
  input  logic              init_mode,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              other_match,
  input  logic              shift_en,
  input  logic [SS_W-1:0]   shift_val,
  output logic              sec_tick,
  output logic              alarm_pulse,
  output logic              alarm_flag,
  output logic              alarm_irq
);
  logic [CNT_W-1:0] cnt;
  logic [SS_W-1:0]  presc;
  logic             irq_en;
  logic             ctrl_we;
  logic             cmp_sel;
  logic             cmp_accept;
  logic             flag_clr;
  logic             hit;
  ssa_cmp_t         cmp;
  logic             unused_wdata;

  assign ctrl_we  = wr_en && (wr_addr == REG_CTRL) && wr_unlock;
  assign cmp_sel  = wr_en && (wr_addr == REG_CMP);
  assign flag_clr = wr_en && (wr_addr == REG_STAT) && wr_data[0];
  assign unused_wdata = ^{wr_data[DATA_W-1:MASK_LSB+MASK_W],
                          wr_data[MASK_LSB-1:IRQ_BIT+1], wr_data[SS_W]};

  always_ff @(posedge clk) begin
    if (!rst_n)       irq_en <= 1'b0;
    else if (ctrl_we) irq_en <= wr_data[IRQ_BIT];
  end

  ssa_prescaler #(.PRESC_RST(PRESC_RST)) u_presc (
    .clk         (clk),
    .rst_n       (rst_n),
    .presc_we    (ctrl_we),
    .presc_wdata (wr_data[SS_W-1:0]),
    .shift_en    (shift_en),
    .shift_val   (shift_val),
    .cnt         (cnt),
    .presc       (presc),
    .sec_tick    (sec_tick)
  );

  ssa_cmp_reg u_cmp (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_sel     (cmp_sel),
    .mask_wdata (wr_data[MASK_LSB +: MASK_W]),
    .ss_wdata   (wr_data[SS_W-1:0]),
    .wr_unlock  (wr_unlock),
    .init_mode  (init_mode),
    .irq_en     (irq_en),
    .cmp        (cmp),
    .cmp_accept (cmp_accept)
  );

  ssa_match u_match (
    .clk         (clk),
    .rst_n       (rst_n),
    .count_low   (cnt[SS_W-1:0]),
    .cmp         (cmp),
    .sec_tick    (sec_tick),
    .other_match (other_match),
    .irq_en      (irq_en),
    .flag_clr    (flag_clr),
    .hit         (hit),
    .alarm_pulse (alarm_pulse),
    .alarm_flag  (alarm_flag),
    .alarm_irq   (alarm_irq)
  );

  always_comb begin
    rd_data = '0;
    case (ssa_addr_e'(rd_addr))
      REG_CMP:  rd_data = pack_cmp(cmp);
      REG_CTRL: rd_data = pack_ctrl(presc, irq_en);
      REG_STAT: rd_data[0] = alarm_flag;
      REG_CNT:  rd_data[CNT_W-1:0] = cnt;
      default:  rd_data = '0;
    endcase
  end

  // R9: the control register holds without the unlock input
  assert_ctrl_protect_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_unlock |=> ($stable(presc) && $stable(irq_en)));

  // R8: an accepted compare write never happens in the locked state
  assert_accept_rule_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_accept |-> (!irq_en || init_mode));
endmodule

// File: tb/ss_alarm_bench.sv
`timescale 1ns/1ps
module ss_alarm_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        wr_unlock = 1'b0;
  logic        init_mode = 1'b0;
  logic [1:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        other_match = 1'b0;
  logic        shift_en = 1'b0;
  logic [14:0] shift_val = '0;
  logic        sec_tick, alarm_pulse, alarm_flag, alarm_irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  int          m_mask = 0;
  logic [14:0] m_ss = '0;
  logic [15:0] m_presc = 16'd255;
  bit          m_irq = 0;

  always #4 clk = ~clk;

  ss_alarm u_ss_alarm (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_unlock(wr_unlock), .init_mode(init_mode), .rd_addr(rd_addr), .rd_data(rd_data),
    .other_match(other_match), .shift_en(shift_en), .shift_val(shift_val),
    .sec_tick(sec_tick), .alarm_pulse(alarm_pulse), .alarm_flag(alarm_flag),
    .alarm_irq(alarm_irq)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit exp_hit(input logic [15:0] c);
    if (!other_match) return 0;
    if (m_mask == 0) return (c == 16'd0);
    for (int b = 0; b < 15; b++)
      if (b < m_mask && c[b] != m_ss[b]) return 0;
    return 1;
  endfunction

  function automatic logic [15:0] nxt(input logic [15:0] c);
    return (c == 16'd0) ? m_presc : c - 16'd1;
  endfunction

  task automatic wr(input logic [1:0] a, input logic [31:0] d, input bit unl, input bit ini);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d; wr_unlock = unl; init_mode = ini;
    @(negedge clk);
    wr_en = 0; wr_unlock = 0; init_mode = 0; wr_data = '0;
  endtask

  task automatic rd_chk(input logic [1:0] a, input logic [31:0] exp, input string req);
    rd_addr = a;
    #1;
    check(rd_data == exp, req, rd_data, exp);
  endtask

  // Cycle-by-cycle model from counter values read at the port.
  task automatic observe(input int n, output int pulses);
    logic [15:0] c, pc;
    bit h, hq, fm, ep;
    pulses = 0; hq = 0; fm = 0;
    rd_addr = 2'd3;
    #1;
    pc = rd_data[15:0];
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      c = rd_data[15:0];
      h = exp_hit(pc);
      check(c == nxt(pc), "R2 count", {16'd0, c}, {16'd0, nxt(pc)});
      check(sec_tick == (c == 16'd0), "R2 tick", {31'd0, sec_tick}, {31'd0, c == 16'd0});
      if (i > 0) begin
        ep = h && !hq;
        check(alarm_pulse == ep, "R11 pulse", {31'd0, alarm_pulse}, {31'd0, ep});
        check(alarm_irq == (ep && m_irq), "R12 irq", {31'd0, alarm_irq}, {31'd0, ep && m_irq});
        fm = fm | ep;
        check(alarm_flag == fm, "R11 flag", {31'd0, alarm_flag}, {31'd0, fm});
        if (alarm_pulse) pulses++;
      end else begin
        fm = alarm_flag;
      end
      hq = h; pc = c;
    end
  endtask

  task automatic wait_cnt(input logic [15:0] v);
    rd_addr = 2'd3;
    for (int k = 0; k < 400; k++) begin
      @(negedge clk);
      if (rd_data[15:0] == v) break;
    end
  endtask

  task automatic t_reset;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rd_chk(2'd0, 32'h0, "R1 compare");
    rd_chk(2'd1, 32'h0000_00FF, "R1 control");
    rd_chk(2'd2, 32'h0, "R1 status");
    rd_chk(2'd3, 32'h0, "R1 counter");
    check({alarm_pulse, alarm_flag, alarm_irq} == 3'b000, "R1 outputs",
          {29'd0, alarm_pulse, alarm_flag, alarm_irq}, 32'h0);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic t_no_qualifier;
    int p;
    wr(2'd1, 32'd9, 1, 0); m_presc = 16'd9;
    wait_cnt(16'd0);
    other_match = 0;
    observe(25, p);
    check(p == 0, "R7 no alarm", p, 0);
  endtask

  task automatic t_mask_zero;
    int p;
    other_match = 1;
    observe(30, p);
    check(p >= 2, "R3 seconds trigger", p, 2);
  endtask

  task automatic t_mask_full;
    int p;
    wr(2'd0, 32'h0F00_0004, 1, 0); m_mask = 15; m_ss = 15'd4;
    rd_chk(2'd0, 32'h0F00_0004, "R5 readback");
    observe(30, p);
    check(p >= 2, "R5 full compare", p, 2);
  endtask

  task automatic t_mask_partial;
    int p;
    wr(2'd0, 32'h0200_7FF1, 1, 0); m_mask = 2; m_ss = 15'h7FF1;
    observe(30, p);
    check(p >= 6, "R4 low bits only", p, 6);
  endtask

  task automatic t_reserved;
    wr(2'd0, 32'hFFFF_FFFF, 1, 0); m_mask = 15; m_ss = 15'h7FFF;
    rd_chk(2'd0, 32'h0F00_7FFF, "R10 compare reserved");
    wr(2'd1, 32'hFFFE_8009, 1, 0);
    rd_chk(2'd1, 32'h0000_0009, "R10 control reserved");
  endtask

  task automatic t_protect;
    wr(2'd0, 32'h0300_0005, 0, 0);
    rd_chk(2'd0, 32'h0F00_7FFF, "R9 compare locked");
    wr(2'd1, 32'd5, 0, 0);
    rd_chk(2'd1, 32'h0000_0009, "R9 control locked");
  endtask

  task automatic t_irq_lock;
    int p;
    wr(2'd0, 32'h0F00_0004, 1, 0); m_mask = 15; m_ss = 15'd4;
    wr(2'd1, 32'h0001_0009, 1, 0); m_irq = 1;
    observe(30, p);
    check(p >= 2, "R12 pulses with enable", p, 2);
    wr(2'd0, 32'h0F00_0006, 1, 0);
    rd_chk(2'd0, 32'h0F00_0004, "R8 write refused");
    wr(2'd0, 32'h0F00_0006, 1, 1); m_ss = 15'd6;
    rd_chk(2'd0, 32'h0F00_0006, "R8 init write");
    observe(20, p);
    wr(2'd1, 32'h0000_0009, 1, 0); m_irq = 0;
    wr(2'd2, 32'h1, 0, 0);
    check(alarm_flag == 0, "R11 clear", {31'd0, alarm_flag}, 32'h0);
  endtask

  task automatic t_collision;
    wr(2'd0, 32'h0F00_0003, 1, 0); m_mask = 15; m_ss = 15'd3;
    other_match = 1;
    wait_cnt(16'd3);
    wr_en = 1; wr_addr = 2'd2; wr_data = 32'h1;
    @(negedge clk);
    wr_en = 0; wr_data = '0;
    check(alarm_pulse == 1, "R11 pulse in clash", {31'd0, alarm_pulse}, 32'h1);
    check(alarm_flag == 1, "R11 set wins", {31'd0, alarm_flag}, 32'h1);
    wr(2'd2, 32'h1, 0, 0);
    check(alarm_flag == 0, "R11 later clear", {31'd0, alarm_flag}, 32'h0);
  endtask

  task automatic t_hold;
    int p;
    wr(2'd1, 32'd0, 1, 0); m_presc = 16'd0;
    wr(2'd0, 32'h0, 1, 0); m_mask = 0; m_ss = '0;
    observe(15, p);
    check(p <= 1, "R11 persistent match", p, 1);
    check(alarm_pulse == 0 && alarm_flag == 1, "R11 held match",
          {30'd0, alarm_pulse, alarm_flag}, 32'h1);
    wr(2'd1, 32'd9, 1, 0); m_presc = 16'd9;
  endtask

  task automatic t_shift;
    int p;
    wr(2'd1, 32'd100, 1, 0); m_presc = 16'd100;
    wr(2'd0, 32'h0F00_0005, 1, 0); m_mask = 15; m_ss = 15'd5;
    wait_cnt(16'd50);
    shift_en = 1; shift_val = 15'h7FDD;
    @(negedge clk);
    shift_en = 0; shift_val = '0;
    rd_chk(2'd3, 32'h0000_800F, "R6 carry into bit 15");
    observe(15, p);
    check(p == 1, "R6 bit 15 ignored", p, 1);
  endtask

  initial begin
    t_reset;
    t_no_qualifier;
    t_mask_zero;
    t_mask_full;
    t_mask_partial;
    t_reserved;
    t_protect;
    t_irq_lock;
    t_collision;
    t_hold;
    t_shift;
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      done = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule